// File: doc/BRIEF.md
# Done-Queue Write Status Threshold

This block watches the descriptor writes that a receive DMA engine makes to its done queue, and it raises a sticky status flag once enough writes have built up. Each write arrives as a one-cycle pulse. The block counts these pulses in a counter that stops at its top value. A 3-bit threshold code picks the trigger level, which is 2 raised to the code value: 1, 2, 4, 8, 16, 32, 64 or 128 descriptors. The flag sets when the count is equal to or greater than that level.

The host reads the flag from a DMA status register. The host clears it with a write-one-to-clear strobe, and that strobe also starts the count again from zero. The count is also driven out of the block so that it can be observed for debug. A change of the threshold code takes effect at once, and the new level is compared with the count already gathered.

Top module: `dq_thresh_top`

## Requirements
- R1: After a synchronous reset, both `status_o` and `count_o` are 0.
- R2: When `desc_wr_i` is 1 and `clear_i` is 0, `count_o` goes up by 1 at the next clock edge. When neither `desc_wr_i` nor `clear_i` is 1, `count_o` keeps its value.
- R3: `count_o` saturates at 128 and never goes above 128, however many further writes arrive.
- R4: The trigger level is 2 raised to the value of `thr_code_i`, so code 0 gives 1 and code 7 gives 128. `status_o` becomes 1 at the clock edge where the updated count becomes equal to or greater than the level, provided `clear_i` is 0 in that cycle.
- R5: While `clear_i` stays 0, `status_o` stays 1 once it is set. This holds whatever later writes arrive and whatever later code changes are made.
- R6: When `clear_i` is 1, `status_o` is 0 and `count_o` is 0 after the next clock edge, provided `desc_wr_i` is 0 in that cycle.
- R7: When `clear_i` and `desc_wr_i` are both 1 in the same cycle, the count restarts at 1 and `status_o` goes to 0. With `thr_code_i` equal to 0, `status_o` becomes 1 again one clock edge later.
- R8: A change of `thr_code_i` is compared with the count already gathered in that same cycle. If the accumulated count is equal to or greater than the new level, `status_o` sets at the next edge, with no new write needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_wr_i | input | 1 | One-cycle pulse for each descriptor written to the done queue |
| thr_code_i | input | 3 | Threshold code; the level is 2 raised to the code value |
| clear_i | input | 1 | Host write-one-to-clear strobe for the status flag |
| status_o | output | 1 | Sticky done-queue write status flag |
| count_o | output | 8 | Current count of descriptor writes, saturating at 128 (debug) |

## Verification
A wrong internal count does not stay hidden. It shows on `count_o` after the very next clock edge, and the reference model compares `count_o` on every cycle. A fault in the level decoding or in the comparison shows one edge later as `status_o` rising early or late. Every code is therefore exercised with exactly the level number of writes, both starting from a clean clear and after a change of code. Faults in the clear logic and the saturation logic show only when a clear and a write land in the same cycle, or after more than 128 writes, so both of these cases are driven on purpose.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int THR_W_DEF = 3;

    typedef struct packed {
        logic wr;
        logic clr;
    } ctl_t;

    function automatic int unsigned level_of(input int unsigned code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/dq_thr_decode.sv
module dq_thr_decode #(
    parameter int THR_W = 3,
    localparam int NUM_LVL = 1 << THR_W,
    localparam int CNT_W = NUM_LVL
) (
    input  logic [THR_W-1:0] code_i,
    output logic [CNT_W-1:0] level_o
);
    logic [CNT_W-1:0] lvl_tab [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign lvl_tab[g] = CNT_W'(dq_pkg::level_of(g));
    end

    assign level_o = lvl_tab[code_i];
endmodule

// File: rtl/dq_counter.sv
module dq_counter #(
    parameter int CNT_W = 8,
    parameter int SAT = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  dq_pkg::ctl_t     ctl_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_n_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        if (ctl_i.clr) begin
            cnt_n = ctl_i.wr ? CNT_W'(1) : '0;
        end else if (ctl_i.wr && (cnt_q != CNT_W'(SAT))) begin
            cnt_n = cnt_q + CNT_W'(1);
        end else begin
            cnt_n = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_n;
    end

    assign cnt_q_o = cnt_q;
    assign cnt_n_o = cnt_n;
endmodule

// File: rtl/dq_status.sv
module dq_status #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_n_i,
    input  logic [CNT_W-1:0] level_i,
    output logic             flag_o
);
    logic flag_q;
    logic hit;

    assign hit = (cnt_n_i >= level_i);

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (clr_i) flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dq_thresh_top.sv
module dq_thresh_top #(
    parameter int THR_W = dq_pkg::THR_W_DEF,
    localparam int NUM_LVL = 1 << THR_W,
    localparam int CNT_W = NUM_LVL,
    localparam int SAT = 1 << (NUM_LVL - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_wr_i,
    input  logic [THR_W-1:0] thr_code_i,
    input  logic             clear_i,
    output logic             status_o,
    output logic [CNT_W-1:0] count_o
);
    dq_pkg::ctl_t     ctl;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] cnt_n;

    assign ctl.wr  = desc_wr_i;
    assign ctl.clr = clear_i;

    dq_thr_decode #(.THR_W(THR_W)) u_dec (
        .code_i (thr_code_i),
        .level_o(level)
    );

    dq_counter #(.CNT_W(CNT_W), .SAT(SAT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .cnt_q_o(count_o),
        .cnt_n_o(cnt_n)
    );

    dq_status #(.CNT_W(CNT_W)) u_sts (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clear_i),
        .cnt_n_i(cnt_n),
        .level_i(level),
        .flag_o (status_o)
    );
endmodule

// File: rtl/dq_thresh_chk.sv
module dq_thresh_chk #(
    parameter int THR_W = 3,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             desc_wr_i,
    input logic [THR_W-1:0] thr_code_i,
    input logic             clear_i,
    input logic             status_o,
    input logic [CNT_W-1:0] count_o
);
    localparam int SAT = 1 << (CNT_W - 1);

    logic [CNT_W-1:0] lvl_now;
    assign lvl_now = CNT_W'(1) << thr_code_i;

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
        else     armed <= 1'b1;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!status_o && count_o == '0));

    assert_incr_R2: assert property (@(posedge clk) disable iff (rst)
        (desc_wr_i && !clear_i && count_o != CNT_W'(SAT)) |=> count_o == $past(count_o) + CNT_W'(1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!desc_wr_i && !clear_i) |=> $stable(count_o));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        armed |-> count_o <= CNT_W'(SAT));

    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && count_o >= lvl_now) |=> status_o);

    assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o) |-> count_o >= (CNT_W'(1) << $past(thr_code_i)));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (status_o && !clear_i) |=> status_o);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!status_o && count_o == CNT_W'($past(desc_wr_i))));

    assert_clr_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (clear_i && desc_wr_i) |=> count_o == CNT_W'(1));
endmodule

bind dq_thresh_top dq_thresh_chk #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .desc_wr_i (desc_wr_i),
    .thr_code_i(thr_code_i),
    .clear_i   (clear_i),
    .status_o  (status_o),
    .count_o   (count_o)
);

// File: tb/dq_thresh_top_tb_top.sv
`timescale 1ns/1ps
module dq_thresh_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0;
    logic [2:0] code = 3'd0;
    logic       clr = 1'b0;
    logic       status;
    logic [7:0] count;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    int    m_cnt = 0;
    bit    m_st = 0;

    always #4 clk = ~clk;

    dq_thresh_top dut_i (
        .clk(clk), .rst(rst), .desc_wr_i(wr), .thr_code_i(code),
        .clear_i(clr), .status_o(status), .count_o(count)
    );

    // behavioural reference model
    always @(posedge clk) begin
        int nc;
        if (rst) begin
            m_cnt = 0;
            m_st  = 0;
        end else begin
            if (clr)                 nc = wr ? 1 : 0;
            else if (wr && m_cnt < 128) nc = m_cnt + 1;
            else                     nc = m_cnt;
            if (clr)                 m_st = 0;
            else if (nc >= (1 << code)) m_st = 1;
            m_cnt = nc;
        end
    end

    task automatic compare();
        checks++;
        if (count !== 8'(m_cnt) || status !== m_st) begin
            errors++;
            $display("FAIL %s: count=%0d status=%0b expected count=%0d status=%0b",
                     cur_req, count, status, m_cnt, m_st);
        end
    endtask

    task automatic step(input bit w, input bit c);
        @(negedge clk);
        compare();
        wr  = w;
        clr = c;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) step(0, 0);
        rst = 1'b0;
        step(0, 0);

        cur_req = "R2";
        code = 3'd7;
        for (int i = 0; i < 6; i++) begin
            step(1, 0);
            step(0, 0);
        end
        step(0, 0);

        cur_req = "R4";
        for (int c = 0; c < 8; c++) begin
            step(0, 1);
            step(0, 0);
            code = 3'(c);
            for (int i = 0; i < (1 << c); i++) step(1, 0);
            step(0, 0);
            step(0, 0);
        end

        cur_req = "R5";
        for (int i = 0; i < 5; i++) step(1, 0);
        code = 3'd7;
        step(0, 0);
        step(0, 0);

        cur_req = "R3";
        step(0, 1);
        for (int i = 0; i < 200; i++) step(1, 0);
        step(0, 0);
        step(0, 0);

        cur_req = "R6";
        step(0, 1);
        step(0, 0);
        step(0, 0);

        cur_req = "R7";
        code = 3'd0;
        step(1, 0);
        step(1, 1);
        step(0, 0);
        step(0, 0);
        step(0, 0);

        cur_req = "R8";
        code = 3'd7;
        step(0, 1);
        for (int i = 0; i < 10; i++) step(1, 0);
        step(0, 0);
        code = 3'd4;
        step(0, 0);
        code = 3'd3;
        step(0, 0);
        step(0, 0);

        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            bit w = ($urandom_range(0, 2) != 0);
            bit c = ($urandom_range(0, 40) == 0);
            if ($urandom_range(0, 60) == 0) code = 3'($urandom_range(0, 7));
            step(w, c);
        end
        step(0, 0);
        step(0, 0);
        finish_run();
    end
endmodule